// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block is a DSP arithmetic unit that multiplies signed halfwords and signed words. Each operand word is split into an upper and a lower half. A per-operand select bit picks one half, which is then sign-extended. The unit offers four operations, chosen by a two-bit mode input:

- a halfword-by-halfword product, optionally added to a single-word accumulator;
- a halfword-by-halfword product added to a double-word accumulator, which arrives as a high and a low word;
- a full word multiplied by a halfword, keeping the middle word of the product, with an optional single-word accumulate;
- a plain halfword product with no accumulate.

A caller presents its operands together with a valid strobe. The result appears on the outputs one clock later and stays there until the next strobe. The single-word accumulating forms report signed overflow in two ways: a per-result flag, and a sticky flag that only reset clears. The halfword width is a parameter; the word is twice that width. With the default of 16, the unit computes 16x16 and 32x16 products over 32-bit words.

Top module: `hmac_top`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe given, `outValid`, `resLo`, `resHi`, `ovNow` and `stickyOv` are all zero.
- R2: `selA`=1 picks bits [W-1:H] of `opA` and `selA`=0 picks bits [H-1:0]. `selB` does the same for `opB`. The picked half is treated as a signed two's-complement value.
- R3: Mode 2'b11 (mul16) returns the signed product of the two picked halves, wrapped to W bits, on `resLo`. `resHi` is 0 and `ovNow` is 0.
- R4: Mode 2'b00 (mac32) returns the halfword product plus signed `accLo`, wrapped to W bits, on `resLo`. `ovNow` is 1 exactly when the true sum falls outside the signed W-bit range, and `resHi` is 0.
- R5: Mode 2'b01 (mac64) adds the sign-extended halfword product to the 2W-bit value {`accHi`,`accLo`} modulo 2^(2W). The result goes to {`resHi`,`resLo`}, and `ovNow` is 0.
- R6: Mode 2'b10 (word) with `accEn`=0 multiplies all of signed `opA` by the picked half of `opB` and returns product bits [W+H-1:H] on `resLo`. `ovNow` is 0 and `resHi` is 0.
- R7: Mode 2'b10 with `accEn`=1 adds signed `accLo` to the value R6 defines, wrapped to W bits. `ovNow` flags signed overflow of that sum, and `resHi` is 0.
- R8: `stickyOv` becomes 1 in the same cycle that any result with `ovNow`=1 appears. It then stays 1 until reset. Results with `ovNow`=0 leave it unchanged.
- R9: A result and `outValid`=1 appear one clock edge after a cycle with `inValid`=1. `outValid` is 0 after a cycle with `inValid`=0, and in that case `resLo`, `resHi` and `ovNow` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | 00 mac32, 01 mac64, 10 word multiply, 11 mul16 |
| accEn | input | 1 | Accumulate enable for the word-multiply mode |
| selA | input | 1 | Half select for opA (1 = upper) |
| selB | input | 1 | Half select for opB (1 = upper) |
| opA | input | 2*HALF_W | First operand word |
| opB | input | 2*HALF_W | Second operand word |
| accLo | input | 2*HALF_W | Single-word accumulator, or low word of the double accumulator |
| accHi | input | 2*HALF_W | High word of the double accumulator |
| outValid | output | 1 | Result registers were loaded on the last edge |
| resLo | output | 2*HALF_W | Result word, or low word of the double result |
| resHi | output | 2*HALF_W | High word of the double result, zero otherwise |
| ovNow | output | 1 | The current result overflowed |
| stickyOv | output | 1 | Accumulated overflow flag, cleared only by reset |

## Verification
The bench instantiates the unit with HALF_W=4, so each word is 8 bits. At that width every value of `opA` can be swept against sixteen `opB` patterns, each pattern under all four half-select combinations, in every mode. Each picked half then takes all sixteen signed values, and the accumulators land on both sides of the signed range often, so wrap and overflow come up many times. The modes run in an order where the non-overflowing ones come first. This shows that the sticky flag stays clear through them and then sets on the first overflowing accumulate.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

  typedef enum logic [1:0] {
    MODE_MAC32 = 2'b00,
    MODE_MAC64 = 2'b01,
    MODE_WORD  = 2'b10,
    MODE_MUL16 = 2'b11
  } hmacMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic useWord;   // word x half product instead of half x half
    logic useAcc32;  // add single-word accumulator, check overflow
    logic useAcc64;  // add double-word accumulator
  } hmacStrobe_t;

endpackage

// File: rtl/hmac_halfsel.sv
module hmac_halfsel #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic              pickUpper,
  output logic [HALF_W-1:0] half
);

  always_comb begin
    if (pickUpper) half = word[WORD_W-1:HALF_W];
    else           half = word[HALF_W-1:0];
  end

endmodule

// File: rtl/hmac_ctrl.sv
module hmac_ctrl
  import hmac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  mode,
  input  logic        accEn,
  output hmacStrobe_t strobe,
  output logic        outValid
);

  hmacMode_t modeSel;

  always_comb begin
    modeSel = hmacMode_t'(mode);
    strobe = '0;
    strobe.load = inValid;
    unique case (modeSel)
      MODE_MAC32: strobe.useAcc32 = 1'b1;
      MODE_MAC64: strobe.useAcc64 = 1'b1;
      MODE_WORD: begin
        strobe.useWord  = 1'b1;
        strobe.useAcc32 = accEn;
      end
      MODE_MUL16: ;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/hmac_datapath.sv
module hmac_datapath
  import hmac_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W,
  localparam int WIDE_W = 3 * HALF_W,
  localparam int DBL_W  = 4 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  hmacStrobe_t       strobe,
  input  logic              selA,
  input  logic              selB,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] accLo,
  input  logic [WORD_W-1:0] accHi,
  output logic [WORD_W-1:0] resLo,
  output logic [WORD_W-1:0] resHi,
  output logic              ovNow,
  output logic              stickyOv
);

  localparam int NUM_OPS = 2;

  logic [WORD_W-1:0] srcWord [NUM_OPS];
  logic              srcSel  [NUM_OPS];
  logic [HALF_W-1:0] srcHalf [NUM_OPS];

  assign srcWord[0] = opA;
  assign srcWord[1] = opB;
  assign srcSel[0]  = selA;
  assign srcSel[1]  = selB;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_half
    hmac_halfsel #(.HALF_W(HALF_W)) sel_i (
      .word     (srcWord[g]),
      .pickUpper(srcSel[g]),
      .half     (srcHalf[g])
    );
  end

  // Half x half product, exact in WORD_W bits
  logic signed [WORD_W-1:0] halfProd;
  assign halfProd = $signed({{HALF_W{srcHalf[0][HALF_W-1]}}, srcHalf[0]})
                  * $signed({{HALF_W{srcHalf[1][HALF_W-1]}}, srcHalf[1]});

  // Word x half product, exact in WIDE_W bits; middle word kept
  logic signed [WIDE_W-1:0] wideProd;
  logic [WORD_W-1:0]        wordMid;
  logic [HALF_W-1:0]        fracBits;
  assign wideProd = $signed({{HALF_W{opA[WORD_W-1]}}, opA})
                  * $signed({{WORD_W{srcHalf[1][HALF_W-1]}}, srcHalf[1]});
  assign {wordMid, fracBits} = wideProd;

  // Single-word accumulate path
  logic [WORD_W-1:0] mulTerm;
  logic [WORD_W-1:0] addTerm;
  logic [WORD_W-1:0] sum32;
  logic              ovRaw;

  always_comb begin
    mulTerm = strobe.useWord ? wordMid : halfProd;
    addTerm = strobe.useAcc32 ? accLo : '0;
    sum32   = mulTerm + addTerm;
    ovRaw   = strobe.useAcc32
            & (mulTerm[WORD_W-1] == addTerm[WORD_W-1])
            & (sum32[WORD_W-1] != mulTerm[WORD_W-1]);
  end

  // Double-word accumulate path
  logic [DBL_W-1:0] sum64;
  assign sum64 = {accHi, accLo} + {{WORD_W{halfProd[WORD_W-1]}}, halfProd};

  logic [WORD_W-1:0] nextLo;
  logic [WORD_W-1:0] nextHi;

  always_comb begin
    if (strobe.useAcc64) begin
      nextLo = sum64[WORD_W-1:0];
      nextHi = sum64[DBL_W-1:WORD_W];
    end else begin
      nextLo = sum32;
      nextHi = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resLo    <= '0;
      resHi    <= '0;
      ovNow    <= 1'b0;
      stickyOv <= 1'b0;
    end else if (strobe.load) begin
      resLo <= nextLo;
      resHi <= nextHi;
      ovNow <= ovRaw;
      if (ovRaw) stickyOv <= 1'b1;
    end
  end

endmodule

// File: rtl/hmac_top.sv
module hmac_top
  import hmac_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        mode,
  input  logic              accEn,
  input  logic              selA,
  input  logic              selB,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [WORD_W-1:0] accLo,
  input  logic [WORD_W-1:0] accHi,
  output logic              outValid,
  output logic [WORD_W-1:0] resLo,
  output logic [WORD_W-1:0] resHi,
  output logic              ovNow,
  output logic              stickyOv
);

  hmacStrobe_t strobe;

  hmac_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .mode    (mode),
    .accEn   (accEn),
    .strobe  (strobe),
    .outValid(outValid)
  );

  hmac_datapath #(.HALF_W(HALF_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .selA    (selA),
    .selB    (selB),
    .opA     (opA),
    .opB     (opB),
    .accLo   (accLo),
    .accHi   (accHi),
    .resLo   (resLo),
    .resHi   (resHi),
    .ovNow   (ovNow),
    .stickyOv(stickyOv)
  );

endmodule

// File: rtl/hmac_checker.sv
module hmac_checker #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        mode,
  input logic              outValid,
  input logic [WORD_W-1:0] resLo,
  input logic [WORD_W-1:0] resHi,
  input logic              ovNow,
  input logic              stickyOv
);

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(resLo) && $stable(resHi) && $stable(ovNow)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'b01) |=> !ovNow);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode == 2'b11) |=> (!ovNow && resHi == '0));

  p_hi_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mode != 2'b01) |=> resHi == '0);

  p_sticky_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    stickyOv |=> stickyOv);

  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    ovNow |-> stickyOv);

endmodule

bind hmac_top hmac_checker #(.HALF_W(HALF_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .mode    (mode),
  .outValid(outValid),
  .resLo   (resLo),
  .resHi   (resHi),
  .ovNow   (ovNow),
  .stickyOv(stickyOv)
);

// File: tb/hmac_top_tb.sv
module hmac_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int H = 4;
  localparam int W = 2 * H;
  localparam longint MASK_W = (64'sd1 <<< W) - 1;
  localparam longint MASK_D = (64'sd1 <<< (2 * W)) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         accEn = 1'b0;
  logic         selA = 1'b0;
  logic         selB = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [W-1:0] accLo = '0;
  logic [W-1:0] accHi = '0;
  logic         outValid;
  logic [W-1:0] resLo;
  logic [W-1:0] resHi;
  logic         ovNow;
  logic         stickyOv;

  int checks = 0;
  int failures = 0;
  logic expSticky = 1'b0;
  logic [W-1:0] lastLo = '0;
  logic [W-1:0] lastHi = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hmac_top #(.HALF_W(H)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .accEn(accEn),
    .selA(selA), .selB(selB), .opA(opA), .opB(opB), .accLo(accLo),
    .accHi(accHi), .outValid(outValid), .resLo(resLo), .resHi(resHi),
    .ovNow(ovNow), .stickyOv(stickyOv)
  );

  function automatic longint sx(input longint v, input int bits);
    longint m;
    m = v & ((64'sd1 <<< bits) - 1);
    if (((m >>> (bits - 1)) & 1) != 0) m = m - (64'sd1 <<< bits);
    return m;
  endfunction

  function automatic longint pickHalf(input longint w, input logic up);
    return up ? sx(w >>> H, H) : sx(w, H);
  endfunction

  task automatic report(input string tag, input logic ok, input string what,
                        input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Applies one operation at a falling edge, checks at the next falling edge
  task automatic runOp(input logic [1:0] m, input logic ae, input logic sa,
                       input logic sb, input int a, input int b, input int lo,
                       input int hi);
    longint pa, pb, prod, s, eLo, eHi, full;
    logic eOv;
    string tag;
    mode = m; accEn = ae; selA = sa; selB = sb;
    opA = W'(a); opB = W'(b); accLo = W'(lo); accHi = W'(hi);
    inValid = 1'b1;
    pa = pickHalf(longint'(a), sa);
    pb = pickHalf(longint'(b), sb);
    prod = pa * pb;
    eHi = 0; eOv = 1'b0;
    case (m)
      2'b11: begin tag = "R2 R3"; eLo = prod & MASK_W; end
      2'b00: begin
        tag = "R2 R4";
        s = prod + sx(longint'(lo), W);
        eLo = s & MASK_W;
        eOv = (s > (MASK_W >>> 1)) || (s < -((MASK_W >>> 1) + 1));
      end
      2'b01: begin
        tag = "R2 R5";
        full = ((longint'(hi) <<< W) | longint'(lo)) + prod;
        full = full & MASK_D;
        eLo = full & MASK_W;
        eHi = (full >>> W) & MASK_W;
      end
      default: begin
        full = (sx(longint'(a), W) * pickHalf(longint'(b), sb)) >>> H;
        if (ae) begin
          tag = "R2 R7";
          s = sx(full, W) + sx(longint'(lo), W);
          eLo = s & MASK_W;
          eOv = (s > (MASK_W >>> 1)) || (s < -((MASK_W >>> 1) + 1));
        end else begin
          tag = "R2 R6";
          eLo = full & MASK_W;
        end
      end
    endcase
    @(negedge clk);
    expSticky = expSticky | eOv;
    report(tag, (outValid === 1'b1) && (resLo === W'(eLo)) &&
                (resHi === W'(eHi)) && (ovNow === eOv),
           "valid/lo/hi/ov",
           {outValid, ovNow, resHi, resLo}, {1'b1, eOv, W'(eHi), W'(eLo)});
    report("R8", stickyOv === expSticky, "sticky", stickyOv, expSticky);
    lastLo = W'(eLo);
    lastHi = W'(eHi);
  endtask

  task automatic sweep(input logic [1:0] m, input logic ae);
    for (int a = 0; a < 256; a++) begin
      for (int bi = 0; bi < 16; bi++) begin
        for (int s = 0; s < 4; s++) begin
          runOp(m, ae, s[1], s[0], a, (bi << 4) | ((bi * 7 + a) & 15),
                (a * 29 + bi * 13 + s * 71) & 255, (a * 3 + bi * 101) & 255);
        end
      end
    end
  endtask

  task automatic checkReset();
    report("R1", (outValid === 1'b0) && (resLo === '0) && (resHi === '0) &&
                 (ovNow === 1'b0) && (stickyOv === 1'b0), "reset state",
           {outValid, ovNow, stickyOv, resHi, resLo}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset();                 // R1 during reset
    rstN = 1'b1;
    @(negedge clk);
    checkReset();                 // R1 after release, no strobe

    // Non-overflowing modes first: sticky must remain clear (R8)
    sweep(2'b11, 1'b0);           // R3
    sweep(2'b01, 1'b0);           // R5
    sweep(2'b10, 1'b0);           // R6
    report("R8", stickyOv === 1'b0, "sticky clear before accumulate",
           stickyOv, 0);
    sweep(2'b00, 1'b0);           // R4
    sweep(2'b10, 1'b1);           // R7

    // Idle cycles: outputs hold and outValid drops (R9)
    inValid = 1'b0;
    opA = '1; opB = '1; accLo = '1; accHi = '1; mode = 2'b01;
    repeat (2) begin
      @(negedge clk);
      report("R9", (outValid === 1'b0) && (resLo === lastLo) &&
                   (resHi === lastHi), "idle hold",
             {outValid, resHi, resLo}, {1'b0, lastHi, lastLo});
    end
    report("R8", stickyOv === 1'b1, "sticky held after idle", stickyOv, 1);

    // Reset clears everything again (R1)
    rstN = 1'b0;
    @(negedge clk);
    checkReset();
    rstN = 1'b1;
    @(negedge clk);
    checkReset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule